// File: doc/BRIEF.md
# I2C Target with Host-Controlled Clock Stretching

This block is a 7-bit-address I2C target. It runs on the system clock and oversamples the bus lines. Each line passes through a short synchronizer. Start and Stop are found from the relative edges of the two lines. The block pulls the lines low only through two open-drain enable outputs: `sda_oe` and `scl_oe` each mean "drive low" when 1.

Toward local software it offers a one-byte buffer, shared by the receive and transmit directions, and a small set of flags:
- a buffer-full flag;
- an overflow flag;
- a direction bit latched from the address byte;
- a per-byte event flag that only software clears.

Two controls shape how SCL is held. A stretch-enable level decides whether SCL is held after received data bytes. A clock-release pulse frees a held SCL.

A controller write loads each accepted byte into the buffer. Software then reads the buffer (`rd_buf`) to make room for the next byte. A controller read always pauses the bus after the address and after each acknowledged byte. During that pause software writes the next byte (`wr_buf`) and then pulses `rel_clk`.

Top module: `i2c_tgt`

## Requirements
- R1: After reset, both enables are 0 and `buf_full`, `ovf`, `rw_stat`, `irq` and `buf_data` are all 0.
- R2: When an address byte matches `TGT_ADDR` in its upper 7 bits and has bit 0 = 0 (write), the block does four things: it clears `rw_stat`, loads the whole address byte into the buffer, sets `buf_full`, and pulls SDA low for the ninth clock.
- R3: When a matching address byte has bit 0 = 1 (read), the block sets `rw_stat`, acknowledges, and then holds SCL low after the ninth clock whatever `stretch_en` is. SCL stays low until `rel_clk` is pulsed.
- R4: An address byte whose upper 7 bits differ from `TGT_ADDR` gets no acknowledge. The block then ignores every later byte until the next Start: no acknowledge, no `irq`, and the buffer is unchanged.
- R5: Each received data byte (first bit on the bus = bit 7) is loaded into the buffer, sets `buf_full` and is acknowledged, provided `buf_full` and `ovf` were both 0 when it completed.
- R6: A byte that completes while `buf_full` or `ovf` is 1 has four outcomes:
  - it gets no acknowledge;
  - it leaves the buffer unchanged;
  - it sets `ovf` if `buf_full` was 1;
  - the block then ignores the bus until the next Start.
  Only `clr_ovf` clears `ovf`.
- R7: `irq` becomes 1 at the falling edge of the ninth clock of every byte after a matching address, including bytes it refuses. Only `clr_irq` clears it.
- R8: With `stretch_en` = 1, SCL is held low after each acknowledged received data byte until `rel_clk`. With `stretch_en` = 0 it is not held there.
- R9: `wr_buf` loads `wr_data` into the buffer and into the transmit shifter. The transmit shifter sends bit 7 first. SDA changes only while SCL is low.
- R10: The controller's acknowledge is sampled at the rising edge of the ninth clock of a transmitted byte. On ACK (SDA low), SCL is held again until `rel_clk`. On NACK (SDA high), `rw_stat` and `buf_full` clear and the block waits for a Start.
- R11: `rd_buf` clears `buf_full`.
- R12: A Start is SDA falling while SCL is high. It restarts address reception from any state, including a repeated Start in the middle of a transfer. A Stop is SDA rising while SCL is high; it releases both lines and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| stretch_en | input | 1 | Hold SCL after received data bytes |
| rel_clk | input | 1 | Pulse: release a held SCL |
| wr_buf | input | 1 | Pulse: write `wr_data` to buffer and transmit shifter |
| wr_data | input | 8 | Byte to transmit |
| rd_buf | input | 1 | Pulse: software has read the buffer |
| clr_irq | input | 1 | Pulse: clear `irq` |
| clr_ovf | input | 1 | Pulse: clear `ovf` |
| buf_data | output | 8 | Buffer contents |
| buf_full | output | 1 | Buffer holds an unread byte |
| ovf | output | 1 | A byte arrived while the buffer was full |
| rw_stat | output | 1 | Direction bit of the last matching address |
| irq | output | 1 | Per-byte event flag |

## Verification
The assertions check, on every cycle, the rules that relate flags and line enables to their causes:
- `ovf` rises only while `buf_full` is set;
- `irq` and `ovf` fall only after their clear pulses;
- `buf_full` falls only after a buffer read or a transmit NACK;
- SCL is grabbed only just after a detected SCL fall and freed only by `rel_clk`, Start or Stop;
- the SDA enable never changes while SCL is high, except on Start or Stop.

Only the bench scenarios can show the rest. That covers whether the acknowledge matches the address and the buffer state, the byte values written to and read from the buffer, and the direction bit. It also covers whether a mismatch or refusal is really ignored until the next Start, whether a repeated Start turns a write into a read, and whether the controller's ACK or NACK leads to another pause or to idle.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_ACK_SETUP,
    ST_ACK_DRIVE,
    ST_TX,
    ST_TX_REL,
    ST_TX_ACK,
    ST_TX_END,
    ST_IGNORE
  } tgt_state_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
// Multi-stage synchronizer with edge detection; idles high like an I2C line.
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic rise,
  output logic fall
);
  logic chain [STAGES];
  logic prev;

  genvar g;
  for (g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b1;
        else     chain[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b1;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= chain[STAGES-1];
  end

  assign dout = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/i2c_tgt_cond.sv
// Bus condition detector: Start and Stop from synchronized lines.
module i2c_tgt_cond (
  input  logic scl_s,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_det,
  output logic stop_det
);
  assign start_det = sda_fall & scl_s;
  assign stop_det  = sda_rise & scl_s;
endmodule

// File: rtl/i2c_tgt_core.sv
// Byte engine: address match, acknowledge, receive, transmit, stretch and host flags.
module i2c_tgt_core
  import i2c_tgt_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 7,
  parameter logic [ADDR_W-1:0] TGT_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              stretch_en,
  input  logic              rel_clk,
  input  logic              wr_buf,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_buf,
  input  logic              clr_irq,
  input  logic              clr_ovf,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [DATA_W-1:0] buf_q,
  output logic              buf_full,
  output logic              ovf,
  output logic              rw_stat,
  output logic              irq
);
  localparam int CNT_W = $clog2(DATA_W) + 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  tgt_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-2:0] rxsr;
  logic [DATA_W-1:0] txsr;
  logic              ack_ok, go_tx, from_rx, m_ack;
  logic [DATA_W-1:0] byte_in;
  logic              busy;

  assign byte_in = {rxsr, sda_s};
  assign busy    = buf_full | ovf;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rxsr     <= '0;
      txsr     <= '1;
      ack_ok   <= 1'b0;
      go_tx    <= 1'b0;
      from_rx  <= 1'b0;
      m_ack    <= 1'b0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      buf_q    <= '0;
      buf_full <= 1'b0;
      ovf      <= 1'b0;
      rw_stat  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      // host-side actions; bus-side updates below take precedence
      if (clr_irq) irq      <= 1'b0;
      if (clr_ovf) ovf      <= 1'b0;
      if (rd_buf)  buf_full <= 1'b0;
      if (rel_clk) scl_oe   <= 1'b0;
      if (wr_buf) begin
        buf_q <= wr_data;
        txsr  <= wr_data;
      end

      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_RX: begin
            if (scl_rise) begin
              rxsr <= byte_in[DATA_W-2:0];
              cnt  <= cnt + 1'b1;
              if (cnt == LAST_BIT) begin
                if (state == ST_ADDR && byte_in[DATA_W-1:1] != TGT_ADDR) begin
                  state <= ST_IGNORE;
                end else begin
                  ack_ok  <= ~busy;
                  go_tx   <= (state == ST_ADDR) & byte_in[0];
                  from_rx <= (state == ST_RX);
                  if (busy) begin
                    if (buf_full) ovf <= 1'b1;
                  end else begin
                    buf_q    <= byte_in;
                    buf_full <= 1'b1;
                    if (state == ST_ADDR) rw_stat <= byte_in[0];
                  end
                  state <= ST_ACK_SETUP;
                end
              end
            end
          end
          ST_ACK_SETUP: begin
            if (scl_fall) begin
              sda_oe <= ack_ok;
              state  <= ST_ACK_DRIVE;
            end
          end
          ST_ACK_DRIVE: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              irq    <= 1'b1;
              cnt    <= '0;
              if (!ack_ok) begin
                state <= ST_IGNORE;
              end else if (go_tx) begin
                scl_oe <= 1'b1;
                state  <= ST_TX;
              end else begin
                if (from_rx && stretch_en) scl_oe <= 1'b1;
                state <= ST_RX;
              end
            end
          end
          ST_TX: begin
            sda_oe <= ~txsr[DATA_W-1];
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
              if (cnt == LAST_BIT) state <= ST_TX_REL;
            end else if (scl_fall) begin
              txsr <= {txsr[DATA_W-2:0], 1'b1};
            end
          end
          ST_TX_REL: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              txsr   <= {txsr[DATA_W-2:0], 1'b1};
              state  <= ST_TX_ACK;
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
              if (sda_s) begin
                rw_stat  <= 1'b0;
                buf_full <= 1'b0;
              end
              state <= ST_TX_END;
            end
          end
          ST_TX_END: begin
            if (scl_fall) begin
              irq <= 1'b1;
              cnt <= '0;
              if (m_ack) begin
                scl_oe <= 1'b1;
                state  <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt #(
  parameter int          DATA_W      = 8,
  parameter int          ADDR_W      = DATA_W - 1,
  parameter int          SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] TGT_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              stretch_en,
  input  logic              rel_clk,
  input  logic              wr_buf,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_buf,
  input  logic              clr_irq,
  input  logic              clr_ovf,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_full,
  output logic              ovf,
  output logic              rw_stat,
  output logic              irq
);
  logic scl_s, scl_rise, scl_fall;
  logic sda_s, sda_rise, sda_fall;
  logic start_det, stop_det;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .din(scl_i),
    .dout(scl_s), .rise(scl_rise), .fall(scl_fall)
  );

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .din(sda_i),
    .dout(sda_s), .rise(sda_rise), .fall(sda_fall)
  );

  i2c_tgt_cond u_cond (
    .scl_s(scl_s), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_core #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TGT_ADDR(TGT_ADDR)
  ) u_core (
    .clk(clk), .rst(rst),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det),
    .stretch_en(stretch_en), .rel_clk(rel_clk),
    .wr_buf(wr_buf), .wr_data(wr_data), .rd_buf(rd_buf),
    .clr_irq(clr_irq), .clr_ovf(clr_ovf),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .buf_q(buf_data), .buf_full(buf_full), .ovf(ovf),
    .rw_stat(rw_stat), .irq(irq)
  );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe,
  input logic scl_oe,
  input logic buf_full,
  input logic ovf,
  input logic irq,
  input logic rw_stat,
  input logic rd_buf,
  input logic clr_irq,
  input logic clr_ovf,
  input logic rel_clk
);
  // R6
  ovf_set_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(buf_full));

  // R6
  ovf_clear_by_host_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf) |-> $past(clr_ovf));

  // R7
  irq_clear_by_host_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(clr_irq));

  // R11
  full_clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(buf_full) |-> ($past(rd_buf) || $past(rw_stat)));

  // R3
  stretch_on_scl_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_oe) |-> $past(scl_fall));

  // R8
  stretch_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_oe) |-> ($past(rel_clk) || $past(start_det) || $past(stop_det)));

  // R9
  sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    ((sda_oe != $past(sda_oe)) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s));
endmodule

bind i2c_tgt i2c_tgt_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det),
  .sda_oe(sda_oe), .scl_oe(scl_oe), .buf_full(buf_full), .ovf(ovf),
  .irq(irq), .rw_stat(rw_stat), .rd_buf(rd_buf), .clr_irq(clr_irq),
  .clr_ovf(clr_ovf), .rel_clk(rel_clk)
);

// File: tb/i2c_tgt_bench.sv
module i2c_tgt_bench;
  localparam logic [6:0] A = 7'h2A;
  localparam int T = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic stretch_en = 1'b0, rel_clk = 1'b0, wr_buf = 1'b0, rd_buf = 1'b0;
  logic clr_irq = 1'b0, clr_ovf = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic scl_oe, sda_oe, buf_full, ovf, rw_stat, irq;
  logic [7:0] buf_data;
  wire scl_line = scl_m & ~scl_oe;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_tgt #(.TGT_ADDR(A)) u_i2c_tgt (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .stretch_en(stretch_en),
    .rel_clk(rel_clk), .wr_buf(wr_buf), .wr_data(wr_data), .rd_buf(rd_buf),
    .clr_irq(clr_irq), .clr_ovf(clr_ovf), .buf_data(buf_data),
    .buf_full(buf_full), .ovf(ovf), .rw_stat(rw_stat), .irq(irq)
  );

  function automatic bit exp_ack(bit match, bit full, bit ov);
    return match && !full && !ov;
  endfunction

  function automatic logic [7:0] addr_byte(logic [6:0] a, bit rw);
    return {a, rw};
  endfunction

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high();
    for (int i = 0; i < 4000 && !scl_line; i++) @(negedge clk);
    chk("R8 SCL line released", scl_line, 1);
  endtask

  task automatic h_rel();     @(negedge clk) rel_clk = 1; @(negedge clk) rel_clk = 0; endtask
  task automatic h_rd();      @(negedge clk) rd_buf  = 1; @(negedge clk) rd_buf  = 0; endtask
  task automatic h_clr_irq(); @(negedge clk) clr_irq = 1; @(negedge clk) clr_irq = 0; endtask
  task automatic h_clr_ovf(); @(negedge clk) clr_ovf = 1; @(negedge clk) clr_ovf = 0; endtask
  task automatic h_wr(input logic [7:0] d);
    @(negedge clk) begin wr_buf = 1; wr_data = d; end
    @(negedge clk) wr_buf = 0;
  endtask

  task automatic bus_start();
    sda_m = 1; wcyc(T); scl_m = 1; wcyc(T); sda_m = 0; wcyc(T); scl_m = 0; wcyc(T);
  endtask

  task automatic bus_stop();
    sda_m = 0; wcyc(T); scl_m = 1; wait_high(); wcyc(T); sda_m = 1; wcyc(T);
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wcyc(T); scl_m = 1; wait_high(); wcyc(T); scl_m = 0; wcyc(2);
    end
    sda_m = 1; wcyc(T); scl_m = 1; wait_high(); wcyc(T/2);
    ack = ~sda_line; wcyc(T/2); scl_m = 0; wcyc(T);
  endtask

  task automatic read_byte(input bit nack, output logic [7:0] d);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wcyc(T); scl_m = 1; wait_high(); wcyc(T/2);
      d[i] = sda_line; wcyc(T/2); scl_m = 0; wcyc(2);
    end
    sda_m = nack; wcyc(T); scl_m = 1; wait_high(); wcyc(T);
    scl_m = 0; wcyc(4); sda_m = 1; wcyc(T);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    bit ack;
    logic [7:0] d;
    logic [7:0] m_buf;
    void'($urandom(32'd4242));
    wcyc(5); rst = 0; wcyc(2);

    // R1 reset state
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 flags", {buf_full, ovf, rw_stat, irq}, 0);
    chk("R1 buf_data", buf_data, 0);

    // Directed: write then repeated start into read (R2 R5 R8 R12 R3 R9 R10)
    stretch_en = 1;
    bus_start();
    write_byte(addr_byte(A, 0), ack);
    chk("R2 write addr ack", ack, 1);
    chk("R2 buf holds addr", buf_data, addr_byte(A, 0));
    chk("R2 rw_stat", rw_stat, 0);
    chk("R2 buf_full", buf_full, 1);
    chk("R7 irq after addr", irq, 1);
    chk("R2 no stretch after write addr", scl_oe, 0);
    h_clr_irq(); h_rd();
    chk("R11 rd clears full", buf_full, 0);
    chk("R7 irq cleared", irq, 0);
    write_byte(8'h96, ack);
    chk("R5 data ack", ack, 1);
    chk("R5 data in buf", buf_data, 8'h96);
    chk("R8 stretch after data", scl_oe, 1);
    scl_m = 1; wcyc(8);
    chk("R8 controller cannot raise SCL", scl_line, 0);
    scl_m = 0; wcyc(2);
    h_clr_irq(); h_rd(); h_rel();
    chk("R8 released", scl_oe, 0);
    bus_start();
    write_byte(addr_byte(A, 1), ack);
    chk("R12 R3 read addr ack after repeated start", ack, 1);
    chk("R3 rw_stat", rw_stat, 1);
    chk("R3 buf holds addr", buf_data, addr_byte(A, 1));
    chk("R3 stretch after read addr", scl_oe, 1);
    h_clr_irq(); h_rd();
    h_wr(8'hC5);
    chk("R9 wr loads buf", buf_data, 8'hC5);
    h_rel();
    read_byte(0, d);
    chk("R9 tx byte", d, 8'hC5);
    chk("R7 irq after tx", irq, 1);
    chk("R10 ack -> stretch", scl_oe, 1);
    h_clr_irq(); h_wr(8'h3C); h_rel();
    read_byte(1, d);
    chk("R9 tx byte2", d, 8'h3C);
    chk("R10 nack clears rw_stat", rw_stat, 0);
    chk("R10 nack no stretch", scl_oe, 0);
    bus_stop();
    h_clr_irq();

    // Directed overflow (R6)
    bus_start();
    write_byte(addr_byte(A, 0), ack);
    chk("R6 addr ack", ack, 1);
    h_clr_irq();
    write_byte(8'h5A, ack);
    chk("R6 nack when full", ack, exp_ack(1, 1, 0));
    chk("R6 ovf set", ovf, 1);
    chk("R6 buf unchanged", buf_data, addr_byte(A, 0));
    chk("R7 irq on refused byte", irq, 1);
    h_clr_irq();
    write_byte(8'h11, ack);
    chk("R6 ignored after refusal", {ack, irq}, 2'b00);
    bus_stop();
    h_rd();
    bus_start();
    write_byte(addr_byte(A, 0), ack);
    chk("R6 nack while ovf", ack, 0);
    chk("R6 ovf held", ovf, 1);
    bus_stop();
    h_clr_ovf(); h_clr_irq();
    chk("R6 clr_ovf", ovf, 0);

    // Random transactions (R4 R5 R8 R9 R10)
    m_buf = buf_data;
    for (int t = 0; t < 12; t++) begin
      bit match = ($urandom % 4) != 0;
      bit dir = $urandom % 2;
      int nb = 1 + ($urandom % 3);
      logic [6:0] a = match ? A : (A ^ 7'(1 + ($urandom % 127)));
      stretch_en = $urandom % 2;
      bus_start();
      write_byte(addr_byte(a, dir), ack);
      chk("R4 addr ack vs match", ack, exp_ack(match, 0, 0));
      if (!match) begin
        chk("R4 no irq", irq, 0);
        write_byte(8'($urandom), ack);
        chk("R4 ignored byte", ack, 0);
        chk("R4 buf unchanged", buf_data, m_buf);
        bus_stop();
      end else if (!dir) begin
        chk("R2 rw", rw_stat, 0);
        h_clr_irq(); h_rd();
        for (int k = 0; k < nb; k++) begin
          logic [7:0] v = 8'($urandom);
          write_byte(v, ack);
          chk("R5 ack", ack, 1);
          chk("R5 data", buf_data, v);
          chk("R8 stretch vs enable", scl_oe, stretch_en);
          m_buf = v;
          h_clr_irq(); h_rd(); h_rel();
        end
        bus_stop();
      end else begin
        chk("R3 rw", rw_stat, 1);
        chk("R3 stretch", scl_oe, 1);
        h_clr_irq(); h_rd();
        for (int k = 0; k < nb; k++) begin
          logic [7:0] v = 8'($urandom);
          bit last = (k == nb - 1);
          h_wr(v); h_rel();
          read_byte(last, d);
          chk("R9 data", d, v);
          chk("R10 stretch after ack", scl_oe, !last);
          m_buf = v;
          h_clr_irq();
        end
        bus_stop();
      end
      h_clr_irq();
    end

    report();
  end
endmodule